// File: doc/BRIEF.md
# In-Order Pending-Destination Scoreboard

This block sits between the issue stage and the execute stage of a short in-order pipeline. It records the destination register of every instruction that has been handed to execute but has not yet written its result. Before the issue stage sends an instruction on, it presents up to two source register indices. The block reports a hit when either index equals a pending destination, and the issue stage stalls on a hit.

Pending destinations are held in a small circular queue in program order. Each instruction that writes a register adds its destination at the tail when it issues. Execute pops the head entry when it writes back. A lookup compares both sources against every live slot at once. A three-state occupancy controller tracks the queue with the states EMPTY, PARTIAL and FULL. Its transitions are: push from EMPTY, fill from PARTIAL to FULL, drain from PARTIAL to EMPTY, release from FULL to PARTIAL, and flush from any state to EMPTY. Pushes and pops that leave the count unchanged keep the current state. A synchronous flush drops every pending entry, for example after a redirect.

Top module: `issue_scoreboard`

## Requirements
- R1: `hit` is combinational. It is high in the same cycle when a valid source index equals the destination of any pending entry. Duplicate destinations are allowed, and each one matches on its own.
- R2: Register index 0 never produces a hit, even when an entry holding destination 0 is pending.
- R3: A source whose valid flag (`rs1_vld`/`rs2_vld`) is low takes no part in matching.
- R4: When `ins_en`, `ins_dst_vld` and `ins_ready` are all high at a clock edge, `ins_dst` is appended as the newest entry. It can be matched from the next cycle on.
- R5: When `ins_en` is high and `ins_dst_vld` is low, no entry is created. Searches do not match `ins_dst`, and the queue capacity is unchanged.
- R6: `ins_ready` is low exactly while DEPTH entries (default 4) are pending. An insert presented while it is low is dropped.
- R7: `rem_en` retires the oldest pending entry at the clock edge, and that entry stops matching in the next cycle. A stalled dependent may therefore issue one cycle after the remove. `rem_en` with no entry pending has no effect.
- R8: Insert and remove may occur in the same cycle. In that cycle `hit` and `ins_ready` reflect the state before both updates, and both take effect at the edge.
- R9: `flush` high at a clock edge empties the queue and overrides any insert or remove in that cycle. In the next cycle `hit` is low and `ins_ready` is high.
- R10: While `rst_n` is low, all entries are cleared. After reset, `hit` is low and `ins_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears the queue |
| flush | input | 1 | Synchronous clear of all pending entries |
| rs1_vld | input | 1 | First source participates in search |
| rs1_idx | input | REG_W | First source register index |
| rs2_vld | input | 1 | Second source participates in search |
| rs2_idx | input | REG_W | Second source register index |
| hit | output | 1 | A valid source matches a pending destination |
| ins_en | input | 1 | Issue strobe for an instruction |
| ins_dst_vld | input | 1 | Issued instruction writes a register |
| ins_dst | input | REG_W | Destination register of the issued instruction |
| ins_ready | output | 1 | Queue can accept another destination |
| rem_en | input | 1 | Execute wrote back; retire oldest entry |

## Verification
`hit` and `ins_ready` depend combinationally on the stored state, so the checks for a given set of inputs sample them in the same cycle. The bench drives each vector at the falling edge and samples two nanoseconds later, before the rising edge commits any update. Inserts, removes and flushes become visible one cycle later, so the effect of a vector is checked by the vector that follows it. Reset is observed in the first cycle after `rst_n` rises.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        SB_EMPTY   = 2'd0,
        SB_PARTIAL = 2'd1,
        SB_FULL    = 2'd2
    } sb_state_e;
endpackage

// File: rtl/sb_ptr_ctrl.sv
module sb_ptr_ctrl
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             push_fire,
    output logic             pop_fire,
    output logic             clear,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             full
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    sb_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    // Accepted operations
    always_comb begin
        clear     = flush;
        push_fire = push_req && (state_q != SB_FULL)  && !flush;
        pop_fire  = pop_req  && (state_q != SB_EMPTY) && !flush;
    end

    // Next-state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (push_fire && !pop_fire) cnt_d = cnt_q + 1'b1;
        if (pop_fire && !push_fire) cnt_d = cnt_q - 1'b1;
        if (flush)                  cnt_d = '0;
        unique case (state_q)
            SB_EMPTY: begin
                if (push_fire)
                    state_d = (DEPTH == 1) ? SB_FULL : SB_PARTIAL;
            end
            SB_PARTIAL: begin
                if (flush)
                    state_d = SB_EMPTY;
                else if (push_fire && !pop_fire && cnt_q == CNT_W'(DEPTH - 1))
                    state_d = SB_FULL;
                else if (pop_fire && !push_fire && cnt_q == CNT_W'(1))
                    state_d = SB_EMPTY;
            end
            SB_FULL: begin
                if (flush)
                    state_d = SB_EMPTY;
                else if (pop_fire)
                    state_d = (DEPTH == 1) ? SB_EMPTY : SB_PARTIAL;
            end
            default: state_d = SB_EMPTY;
        endcase
    end

    // State register and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SB_EMPTY;
            cnt_q   <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (push_fire) wr_ptr <= bump(wr_ptr);
                if (pop_fire)  rd_ptr <= bump(rd_ptr);
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        full = (state_q == SB_FULL);
    end
endmodule

// File: rtl/sb_slot_store.sv
module sb_slot_store #(
    parameter int DEPTH = 4,
    parameter int REG_W = 5,
    parameter int PTR_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        push_fire,
    input  logic                        pop_fire,
    input  logic [PTR_W-1:0]            wr_ptr,
    input  logic [PTR_W-1:0]            rd_ptr,
    input  logic [REG_W-1:0]            push_dst,
    output logic [DEPTH-1:0]            slot_vld,
    output logic [DEPTH-1:0][REG_W-1:0] slot_dst
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic wr_here, rd_here;
        assign wr_here = push_fire && (wr_ptr == PTR_W'(i));
        assign rd_here = pop_fire  && (rd_ptr == PTR_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_vld[i] <= 1'b0;
                slot_dst[i] <= '0;
            end else begin
                if (clear)        slot_vld[i] <= 1'b0;
                else if (wr_here) slot_vld[i] <= 1'b1;
                else if (rd_here) slot_vld[i] <= 1'b0;
                if (wr_here)      slot_dst[i] <= push_dst;
            end
        end
    end
endmodule

// File: rtl/sb_match.sv
module sb_match #(
    parameter int DEPTH = 4,
    parameter int REG_W = 5
) (
    input  logic [DEPTH-1:0]            slot_vld,
    input  logic [DEPTH-1:0][REG_W-1:0] slot_dst,
    input  logic                        rs1_vld,
    input  logic [REG_W-1:0]            rs1_idx,
    input  logic                        rs2_vld,
    input  logic [REG_W-1:0]            rs2_idx,
    output logic                        hit
);
    logic             s1_live, s2_live;
    logic [DEPTH-1:0] per_slot;

    assign s1_live = rs1_vld && (rs1_idx != '0);
    assign s2_live = rs2_vld && (rs2_idx != '0);

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign per_slot[i] = slot_vld[i] &&
            ((s1_live && slot_dst[i] == rs1_idx) ||
             (s2_live && slot_dst[i] == rs2_idx));
    end

    assign hit = |per_slot;
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard #(
    parameter int DEPTH = 4,
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             rs1_vld,
    input  logic [REG_W-1:0] rs1_idx,
    input  logic             rs2_vld,
    input  logic [REG_W-1:0] rs2_idx,
    output logic             hit,
    input  logic             ins_en,
    input  logic             ins_dst_vld,
    input  logic [REG_W-1:0] ins_dst,
    output logic             ins_ready,
    input  logic             rem_en
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic                        push_fire, pop_fire, clear, full;
    logic [PTR_W-1:0]            wr_ptr, rd_ptr;
    logic [DEPTH-1:0]            slot_vld;
    logic [DEPTH-1:0][REG_W-1:0] slot_dst;

    sb_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push_req  (ins_en && ins_dst_vld),
        .pop_req   (rem_en),
        .push_fire (push_fire),
        .pop_fire  (pop_fire),
        .clear     (clear),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .full      (full)
    );

    sb_slot_store #(.DEPTH(DEPTH), .REG_W(REG_W), .PTR_W(PTR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .push_fire (push_fire),
        .pop_fire  (pop_fire),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .push_dst  (ins_dst),
        .slot_vld  (slot_vld),
        .slot_dst  (slot_dst)
    );

    sb_match #(.DEPTH(DEPTH), .REG_W(REG_W)) u_match (
        .slot_vld (slot_vld),
        .slot_dst (slot_dst),
        .rs1_vld  (rs1_vld),
        .rs1_idx  (rs1_idx),
        .rs2_vld  (rs2_vld),
        .rs2_idx  (rs2_idx),
        .hit      (hit)
    );

    assign ins_ready = !full;
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int DEPTH = 4,
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             rs1_vld,
    input logic [REG_W-1:0] rs1_idx,
    input logic             rs2_vld,
    input logic [REG_W-1:0] rs2_idx,
    input logic             hit,
    input logic             ins_en,
    input logic             ins_dst_vld,
    input logic             ins_ready,
    input logic             rem_en
);
    localparam int OCC_W = $clog2(DEPTH + 1);

    // Occupancy model built from port activity only
    logic [OCC_W-1:0] occ;
    logic             acc_push, acc_pop;
    assign acc_push = ins_en && ins_dst_vld && ins_ready && !flush;
    assign acc_pop  = rem_en && (occ != '0) && !flush;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   occ <= '0;
        else if (flush)               occ <= '0;
        else if (acc_push && !acc_pop) occ <= occ + 1'b1;
        else if (acc_pop && !acc_push) occ <= occ - 1'b1;
    end

    p_empty_no_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> !hit);

    p_zero_never_hits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rs1_idx == '0 && rs2_idx == '0) |-> !hit);

    p_invalid_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rs1_vld && !rs2_vld) |-> !hit);

    p_ready_tracks_occ_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ins_ready == (occ < OCC_W'(DEPTH)));

    p_swap_keeps_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_push && acc_pop) |=> $stable(ins_ready));

    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ins_ready && !hit));
endmodule

bind issue_scoreboard sb_checker #(.DEPTH(DEPTH), .REG_W(REG_W)) u_sb_chk (.*);

// File: tb/test_issue_scoreboard.sv
module test_issue_scoreboard;
    localparam int DEPTH = 4;
    localparam int REG_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush = 1'b0;
    logic             rs1_vld = 1'b0, rs2_vld = 1'b0;
    logic [REG_W-1:0] rs1_idx = '0, rs2_idx = '0;
    logic             hit;
    logic             ins_en = 1'b0, ins_dst_vld = 1'b0;
    logic [REG_W-1:0] ins_dst = '0;
    logic             ins_ready;
    logic             rem_en = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    issue_scoreboard #(.DEPTH(DEPTH), .REG_W(REG_W)) i_issue_scoreboard (.*);

    typedef struct packed {
        logic       fl;
        logic       ie;
        logic       dv;
        logic [4:0] dst;
        logic       rm;
        logic       v1;
        logic [4:0] s1;
        logic       v2;
        logic [4:0] s2;
        logic       eh;
        logic       er;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 17;
    // fl ie dv dst rm | v1 s1 v2 s2 | exp_hit exp_ready | requirement
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,1'b1,5'd3, 1'b0, 1'b1,5'd3, 1'b0,5'd0, 1'b0,1'b1, 4'd4}, // R4 push 3
        '{1'b0,1'b1,1'b1,5'd0, 1'b0, 1'b1,5'd3, 1'b0,5'd0, 1'b1,1'b1, 4'd1}, // R1 3 seen, push 0
        '{1'b0,1'b0,1'b0,5'd0, 1'b0, 1'b1,5'd0, 1'b1,5'd0, 1'b0,1'b1, 4'd2}, // R2 index 0
        '{1'b0,1'b1,1'b0,5'd9, 1'b0, 1'b0,5'd3, 1'b1,5'd7, 1'b0,1'b1, 4'd3}, // R3, R5 no-dst issue
        '{1'b0,1'b1,1'b1,5'd5, 1'b0, 1'b0,5'd0, 1'b1,5'd9, 1'b0,1'b1, 4'd5}, // R5 9 absent, push 5
        '{1'b0,1'b1,1'b1,5'd3, 1'b0, 1'b1,5'd5, 1'b0,5'd0, 1'b1,1'b1, 4'd5}, // R5 room left, push dup 3
        '{1'b0,1'b1,1'b1,5'd12,1'b0, 1'b1,5'd12,1'b0,5'd0, 1'b0,1'b0, 4'd6}, // R6 full, push refused
        '{1'b0,1'b0,1'b0,5'd0, 1'b1, 1'b1,5'd12,1'b0,5'd0, 1'b0,1'b0, 4'd6}, // R6 12 absent, remove
        '{1'b0,1'b0,1'b0,5'd0, 1'b0, 1'b1,5'd3, 1'b0,5'd0, 1'b1,1'b1, 4'd1}, // R1 duplicate 3 remains
        '{1'b0,1'b1,1'b1,5'd7, 1'b1, 1'b1,5'd7, 1'b0,5'd0, 1'b0,1'b1, 4'd8}, // R8 swap, old view
        '{1'b0,1'b0,1'b0,5'd0, 1'b1, 1'b1,5'd7, 1'b1,5'd0, 1'b1,1'b1, 4'd8}, // R8 7 now seen
        '{1'b0,1'b0,1'b0,5'd0, 1'b1, 1'b1,5'd5, 1'b0,5'd0, 1'b0,1'b1, 4'd7}, // R7 5 retired
        '{1'b0,1'b0,1'b0,5'd0, 1'b1, 1'b1,5'd3, 1'b1,5'd7, 1'b1,1'b1, 4'd7}, // R7 7 still pending
        '{1'b0,1'b0,1'b0,5'd0, 1'b1, 1'b1,5'd7, 1'b0,5'd0, 1'b0,1'b1, 4'd7}, // R7 empty remove
        '{1'b0,1'b1,1'b1,5'd4, 1'b0, 1'b1,5'd4, 1'b0,5'd0, 1'b0,1'b1, 4'd7}, // R7 empty kept, push 4
        '{1'b1,1'b1,1'b1,5'd6, 1'b1, 1'b1,5'd4, 1'b0,5'd0, 1'b1,1'b1, 4'd9}, // R9 flush beats ops
        '{1'b0,1'b0,1'b0,5'd0, 1'b0, 1'b1,5'd4, 1'b1,5'd6, 1'b0,1'b1, 4'd9}  // R9 nothing left
    };

    task automatic check(input string rq, input logic act, input logic exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", rq, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        flush = 0; ins_en = 0; ins_dst_vld = 0; ins_dst = '0; rem_en = 0;
        rs1_vld = 0; rs1_idx = '0; rs2_vld = 0; rs2_idx = '0;
    endtask

    task automatic fill_all();
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            idle_inputs();
            ins_en = 1; ins_dst_vld = 1; ins_dst = REG_W'(k + 10);
        end
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        string tag;
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        rs1_vld = 1; rs1_idx = 5'd3;
        #2;
        check("R10", hit, 1'b0, "hit after reset");
        check("R10", ins_ready, 1'b1, "ready after reset");

        // Vector table
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            flush = VEC[k].fl; ins_en = VEC[k].ie; ins_dst_vld = VEC[k].dv;
            ins_dst = VEC[k].dst; rem_en = VEC[k].rm;
            rs1_vld = VEC[k].v1; rs1_idx = VEC[k].s1;
            rs2_vld = VEC[k].v2; rs2_idx = VEC[k].s2;
            #2;
            tag = $sformatf("R%0d vec%0d", VEC[k].rq, k);
            check(tag, hit, VEC[k].eh, "hit");
            check(tag, ins_ready, VEC[k].er, "ready");
        end

        // R9: flush from full
        fill_all();
        #2;
        check("R9", ins_ready, 1'b0, "full before flush");
        @(negedge clk);
        flush = 1;
        @(negedge clk);
        idle_inputs();
        rs1_vld = 1; rs1_idx = 5'd10;
        #2;
        check("R9", ins_ready, 1'b1, "ready after flush of full queue");
        check("R9", hit, 1'b0, "hit after flush of full queue");

        // R10: reset in mid-run clears pending entries
        fill_all();
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        rs1_vld = 1; rs1_idx = 5'd11;
        #2;
        check("R10", hit, 1'b0, "hit after mid-run reset");
        check("R10", ins_ready, 1'b1, "ready after mid-run reset");

        // R7: stalled dependent released one cycle after remove
        @(negedge clk);
        idle_inputs();
        ins_en = 1; ins_dst_vld = 1; ins_dst = 5'd21;
        @(negedge clk);
        idle_inputs();
        rs2_vld = 1; rs2_idx = 5'd21; rem_en = 1;
        #2;
        check("R7", hit, 1'b1, "stall while producer pending");
        @(negedge clk);
        rem_en = 0;
        ins_en = 1; ins_dst_vld = 1; ins_dst = 5'd22;
        #2;
        check("R7", hit, 1'b0, "release after remove");
        @(negedge clk);
        idle_inputs();
        rs1_vld = 1; rs1_idx = 5'd22;
        #2;
        check("R4", hit, 1'b1, "dependent inserted its destination");

        @(negedge clk);
        idle_inputs();
        finish_run();
    end
endmodule